// File: doc/BRIEF.md
# Decimal-Programmed Clock Divider

This block divides its clock by a modulus N that comes from ten static program bits, read as three binary-coded decimal digits. It emits one single-cycle output pulse for every N rising edges of the clock. In a frequency synthesizer the clock is the prescaled VCO signal, and the pulse train goes to the phase comparator. The loop locks the VCO at N times the comparison frequency, so the program bits select the channel.

The program word holds a ones digit in bits 3:0, a tens digit in bits 7:4 and a two-bit hundreds digit in bits 9:8. Inside the block there is one decade down-counter per digit, and the counters are linked by a borrow chain. When every digit reaches zero, the block raises the output for one clock and reloads the counters with N−1, decoded from the program bits at that moment. Because the program bits are sampled only on a reload, a change in the middle of a period does not shorten the period already in progress. Out-of-range digit codes are clamped to 9, and a modulus below 2 is raised to 2.

Top module: `bcd_divn`

## Requirements
- R1: `prog[3:0]` is the ones digit (weights 1, 2, 4, 8), `prog[7:4]` is the tens digit (weights 10, 20, 40, 80) and `prog[9:8]` is the hundreds digit (weights 100, 200). N = ones + 10·tens + 100·hundreds.
- R2: Outside reset, `div_out` is high for exactly one clock and then low for N−1 clocks, so consecutive pulses are N clocks apart.
- R3: Ones=1, tens=9 divides by 91. Ones=5, tens=3, hundreds=1 divides by 135.
- R4: A ones or tens digit code of 10 to 15 acts as 9. For example, ones=15 gives N=9, and tens=12 with ones=3 gives N=93.
- R5: A decoded modulus of 0 or 1 acts as 2.
- R6: The largest modulus is 399 (all digits at 9 and hundreds at 3), and the output period at that setting is 399 clocks.
- R7: `rst` is synchronous and active high. While it is sampled high, `div_out` stays low and the counter loads N−1. The first pulse comes on the (N−1)th rising edge after the last edge at which `rst` was sampled high.
- R8: A program change takes effect only at the next reload. The period in progress keeps the old N, and the period after the next pulse uses the new N.
- R9: Between reloads, the counter's decimal value drops by exactly one per clock, and every digit stays in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided (prescaled VCO signal) |
| rst | input | 1 | Synchronous active-high reset; loads the counter from `prog` |
| prog | input | 10 | Modulus program: ones [3:0], tens [7:4], hundreds [9:8] |
| div_out | output | 1 | One-clock pulse every N clocks |

## Verification
The assertions check on every cycle that each digit stays decimal and that the counter's decimal value steps down by exactly one. They also check that a pulse never lasts longer than one clock, that a reload takes the value decoded at the reload cycle, and that the decoded load value stays between 1 and 398. Other behaviours show up only in the bench's scenarios, because they depend on the whole program-to-period path over many cycles. These are the actual periods for the named moduli, the clamping of illegal digits and tiny moduli, the first-pulse delay after reset release, and the deferred effect of a program change made mid-period.

// File: rtl/bcd_divn_pkg.sv
package bcd_divn_pkg;

    localparam int DIG_W = 4;
    localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

    typedef logic [DIG_W-1:0] digit_t;

    typedef struct packed {
        digit_t cnt;
    } cell_state_t;

    function automatic digit_t clamp_digit(input digit_t d);
        return (d > DIG_MAX) ? DIG_MAX : d;
    endfunction

endpackage

// File: rtl/bcd_divn_load.sv
// Turns the program word into the reload value N-1, as BCD digits.
module bcd_divn_load
    import bcd_divn_pkg::*;
#(
    parameter int PROG_W = 10,
    parameter int NDIG   = 3,
    parameter int TOP_W  = 2
) (
    input  logic [PROG_W-1:0]     prog,
    output logic [DIG_W*NDIG-1:0] load_flat
);

    digit_t dig   [NDIG];
    digit_t dec   [NDIG];
    logic   upper_zero;
    logic   tiny;
    logic   borrow;

    always_comb begin
        for (int i = 0; i < NDIG; i++) begin
            digit_t raw;
            raw = '0;
            if (i == NDIG - 1) begin
                raw[TOP_W-1:0] = prog[PROG_W-1 -: TOP_W];
            end else begin
                raw = prog[DIG_W*i +: DIG_W];
            end
            dig[i] = clamp_digit(raw);
        end

        // Moduli 0 and 1 are raised to 2, which means a reload value of 1.
        upper_zero = 1'b1;
        for (int i = 1; i < NDIG; i++) begin
            if (dig[i] != '0) upper_zero = 1'b0;
        end
        tiny = upper_zero && (dig[0] < 4'd2);

        // Decimal decrement through the borrow chain.
        borrow = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (!borrow) begin
                dec[i] = dig[i];
            end else if (dig[i] == '0) begin
                dec[i] = DIG_MAX;
            end else begin
                dec[i] = dig[i] - 4'd1;
                borrow = 1'b0;
            end
        end

        for (int i = 0; i < NDIG; i++) begin
            if (tiny) begin
                load_flat[DIG_W*i +: DIG_W] = (i == 0) ? 4'd1 : 4'd0;
            end else begin
                load_flat[DIG_W*i +: DIG_W] = dec[i];
            end
        end
    end

endmodule

// File: rtl/bcd_decade_cell.sv
// One decimal digit of the down-counter: it wraps from 0 to 9 and borrows from the next digit up.
module bcd_decade_cell
    import bcd_divn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  digit_t load_val,
    input  logic   dec_in,
    output digit_t cnt,
    output logic   borrow_out
);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || load) begin
            st_d.cnt = load_val;
        end else if (dec_in) begin
            st_d.cnt = (st_q.cnt == '0) ? DIG_MAX : st_q.cnt - 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt        = st_q.cnt;
    assign borrow_out = dec_in && (st_q.cnt == '0);

endmodule

// File: rtl/bcd_divn.sv
module bcd_divn
    import bcd_divn_pkg::*;
#(
    parameter int PROG_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PROG_W-1:0] prog,
    output logic              div_out
);

    localparam int NDIG   = (PROG_W + DIG_W - 1) / DIG_W;
    localparam int TOP_W  = PROG_W - DIG_W * (NDIG - 1);
    localparam int FLAT_W = DIG_W * NDIG;

    logic [FLAT_W-1:0] load_flat;
    logic [FLAT_W-1:0] cnt_flat;
    logic [NDIG:0]     chain;
    logic              all_zero;

    bcd_divn_load #(
        .PROG_W (PROG_W),
        .NDIG   (NDIG),
        .TOP_W  (TOP_W)
    ) u_load (
        .prog      (prog),
        .load_flat (load_flat)
    );

    assign chain[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        bcd_decade_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .load       (all_zero),
            .load_val   (load_flat[DIG_W*g +: DIG_W]),
            .dec_in     (chain[g]),
            .cnt        (cnt_flat[DIG_W*g +: DIG_W]),
            .borrow_out (chain[g+1])
        );
    end

    assign all_zero = (cnt_flat == '0);
    assign div_out  = all_zero && !rst;

endmodule

// File: rtl/bcd_divn_chk.sv
module bcd_divn_chk #(
    parameter int NDIG = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              div_out,
    input logic [4*NDIG-1:0] cnt_flat,
    input logic [4*NDIG-1:0] load_flat
);

    function automatic int dec_val(input logic [4*NDIG-1:0] v);
        int acc;
        int w;
        acc = 0;
        w   = 1;
        for (int i = 0; i < NDIG; i++) begin
            acc = acc + int'(v[4*i +: 4]) * w;
            w   = w * 10;
        end
        return acc;
    endfunction

    function automatic logic digits_ok(input logic [4*NDIG-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        digits_ok(cnt_flat)); // R9

    AST_DECIMAL_STEP: assert property (@(posedge clk) disable iff (rst)
        !div_out |=> dec_val(cnt_flat) == $past(dec_val(cnt_flat)) - 1); // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out); // R2

    AST_RELOAD_PROGRAM: assert property (@(posedge clk) disable iff (rst)
        div_out |=> dec_val(cnt_flat) == $past(dec_val(load_flat))); // R8

    AST_MIN_MODULUS: assert property (@(posedge clk) disable iff (rst)
        dec_val(load_flat) >= 1); // R5

    AST_MAX_MODULUS: assert property (@(posedge clk) disable iff (rst)
        dec_val(load_flat) <= 398); // R6

endmodule

bind bcd_divn bcd_divn_chk #(.NDIG(NDIG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_out   (div_out),
    .cnt_flat  (cnt_flat),
    .load_flat (load_flat)
);

// File: tb/bcd_divn_tb.sv
module bcd_divn_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] prog = '0;
    logic       div_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam int LIMIT = 1000;
    localparam int NCASE = 9;

    // program word {hundreds[1:0], tens[3:0], ones[3:0]}, expected N, requirement number
    localparam logic [9:0] T_PROG [NCASE] = '{
        10'b00_1001_0001,  // R3: 91
        10'b01_0011_0101,  // R3: 135
        10'b00_0000_0010,  // R2: 2
        10'b11_1001_1001,  // R6: 399
        10'b00_0000_1111,  // R4: ones 15 -> 9
        10'b00_1100_0011,  // R4: tens 12 -> 93
        10'b00_0000_0000,  // R5: 0 -> 2
        10'b00_0000_0001,  // R5: 1 -> 2
        10'b10_0000_0111   // R1: 207
    };
    localparam int T_N   [NCASE] = '{91, 135, 2, 399, 9, 93, 2, 2, 207};
    localparam int T_REQ [NCASE] = '{3, 3, 2, 6, 4, 4, 5, 5, 1};

    bcd_divn u_dut (
        .clk     (clk),
        .rst     (rst),
        .prog    (prog),
        .div_out (div_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts falling edges until div_out is seen high.
    task automatic wait_pulse(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_out && k < LIMIT);
    endtask

    task automatic start(input logic [9:0] p);
        @(negedge clk);
        prog = p;
        rst  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int k;
        string tag;

        // R7: output held low through a long reset
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R7 reset low", int'(div_out), 0);
        end

        for (int c = 0; c < NCASE; c++) begin
            tag = $sformatf("R%0d case %0d", T_REQ[c], c);
            start(T_PROG[c]);
            wait_pulse(k);
            check({tag, " first pulse (R7)"}, k, T_N[c] - 1);
            @(negedge clk);
            check({tag, " width (R2)"}, int'(div_out), 0);
            k = 1;
            while (!div_out && k < LIMIT) begin
                @(negedge clk);
                k++;
            end
            check({tag, " period"}, k, T_N[c]);
        end

        // R8: program change in mid-period
        start(10'b00_0001_0000);
        wait_pulse(k);
        check("R8 first", k, 9);
        repeat (4) @(negedge clk);
        prog = 10'b00_0010_0101;
        k = 4;
        while (!div_out && k < LIMIT) begin
            @(negedge clk);
            k++;
        end
        check("R8 old period kept", k, 10);
        wait_pulse(k);
        check("R8 new period", k, 25);

        // R7: reset asserted mid-count restarts the count
        start(10'b00_1001_0001);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 low in reset", int'(div_out), 0);
        rst = 1'b0;
        wait_pulse(k);
        check("R7 restart", k, 90);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule